// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write port and the program/erase engine of a NOR-style flash controller. Each host write arrives as a one-cycle strobe with an address, a data word and a flag that says whether the address is a byte address or a word address. The decoder checks each write against the coded two-write unlock prefix. It recognises reset to read-array, identification (autoselect), program, chip erase, block erase, erase suspend and erase resume. For each operation it raises one-cycle start pulses for the engine behind it.

For block erase, the decoder collects a one-hot mask of the eleven array blocks. It keeps a timed window open in which further blocks can be added. When the window closes, the erase is launched with the collected mask. The decoder also tracks whether the engine is busy, whether an erase is suspended and whether identification mode is active. The engine reports completion on the `done` input.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in read-array mode: `busy`, `suspended` and `autoselect` are 0, `erase_mask` is 0, and no start, suspend or resume pulse is raised.
- R2: In word mode (`wr_byte`=0) the unlock prefix is data AAh at word address 5555h followed by data 55h at word address 2AAAh. Only address bits 14:0 are compared, so bits 17:15 may take any value.
- R3: In byte mode (`wr_byte`=1) the unlock addresses are byte addresses AAAAh and 5555h, compared on bits 15:0 only. The block of a byte address is taken from its word address, which is bits 18:1.
- R4: Unlock followed by A0h at the first unlock address makes the next write a program write. `prog_start` pulses for one cycle after that write, with `prog_addr`, `prog_data` and `prog_byte` holding its fields. `busy` is 1 from that cycle on.
- R5: Unlock, 80h, unlock again, then 10h at the first unlock address pulses `erase_start` with `erase_chip`=1 and `erase_mask`=7FFh. `busy` is 1 from that cycle on.
- R6: Unlock, 80h, unlock again, then 30h at any address selects the block containing that address and opens the add window. `erase_start` pulses, with `erase_chip`=0 and the collected mask, exactly WIN_CYC cycles after the last accepted block write.
- R7: Inside the window, each further 30h write ORs its block into the mask and restarts the full window. Any other write inside the window drops the pending erase: the mask returns to 0 and no erase starts.
- R8: With TOP_BOOT=0, block n is bit n of `erase_mask`. For word addresses: 0000h-1FFFh is block 0, 2000h-2FFFh is block 1, 3000h-3FFFh is block 2, 4000h-7FFFh is block 3, and each following 32K-word range 8000h·k to 8000h·k+7FFFh (k=1..7) is block 3+k.
- R9: Unlock followed by 90h at the first unlock address sets `autoselect`. The next write of any kind clears it.
- R10: While a program is busy every write is ignored, including B0h. While an erase is busy, every write except B0h is ignored.
- R11: During a busy erase, B0h at any address pulses `suspend_pulse`, drops `busy` and sets `suspended`. While suspended, only 30h is accepted: it pulses `resume_pulse` and returns to busy erase. All other writes and `done` are ignored.
- R12: Any wrong data or wrong address at a step of a command sequence returns the decoder to read-array mode. No part of the abandoned sequence carries over to later writes. A single F0h write leaves the decoder in read-array mode.
- R13: `done` during a busy program or busy erase returns the decoder to read-array mode: `busy` falls and `erase_mask` is cleared on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | WADDR_W+1 | Write address (byte address in byte mode, word address in bits WADDR_W-1:0 in word mode) |
| wr_data | input | DATA_W | Write data; commands are read from bits 7:0 |
| wr_byte | input | 1 | 1 = byte-mode addressing, 0 = word-mode addressing |
| done | input | 1 | Completion strobe from the program/erase engine |
| prog_start | output | 1 | One-cycle program launch |
| prog_addr | output | WADDR_W+1 | Address captured from the program write |
| prog_data | output | DATA_W | Data captured from the program write |
| prog_byte | output | 1 | Mode flag captured from the program write |
| erase_start | output | 1 | One-cycle erase launch |
| erase_chip | output | 1 | Set with `erase_start` when the erase is a chip erase |
| erase_mask | output | 11 | One-hot set of blocks selected for erase |
| suspend_pulse | output | 1 | One-cycle erase-suspend request |
| resume_pulse | output | 1 | One-cycle erase-resume request |
| busy | output | 1 | Program or erase in progress |
| suspended | output | 1 | Erase suspended |
| autoselect | output | 1 | Identification mode active |

## Verification
The hardest behaviour to reach from the ports is the add window. Its close must land exactly WIN_CYC cycles after the last accepted block write, and every addition must restart it. The bench therefore counts cycles from each confirm or add write to the `erase_start` pulse. It mixes directed cases, where an addition arrives after the window has partly run down, with randomly chosen runs of one to three block writes in both addressing modes. Each run's mask is compared with one the bench builds from the block ranges. Abandoned sequences are followed by a write that would complete a program if any state had carried over, and the bench checks that no pulse appears.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int NUM_BLK = 11;

  localparam logic [7:0] OP_KEY_A    = 8'hAA;
  localparam logic [7:0] OP_KEY_B    = 8'h55;
  localparam logic [7:0] OP_RESET    = 8'hF0;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_PROGRAM  = 8'hA0;
  localparam logic [7:0] OP_ERS_ARM  = 8'h80;
  localparam logic [7:0] OP_ERS_CHIP = 8'h10;
  localparam logic [7:0] OP_ERS_BLK  = 8'h30;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;

  typedef enum logic [3:0] {
    ST_READ, ST_KEY1, ST_KEY2, ST_PRG_ARG, ST_ERS_ARM,
    ST_ERS_KEY1, ST_ERS_KEY2, ST_ERS_WIN, ST_BUSY_PRG, ST_BUSY_ERS, ST_SUSP
  } fcd_state_e;

  // Block number from the six most significant word-address bits.
  function automatic logic [3:0] blk_of_field(input logic [5:0] f, input logic top_boot);
    logic [3:0] r;
    if (!top_boot) begin
      if (f[5:3] != 3'd0)       r = 4'd3 + {1'b0, f[5:3]};
      else if (f[2])            r = 4'd3;
      else if (f[1])            r = f[0] ? 4'd2 : 4'd1;
      else                      r = 4'd0;
    end else begin
      if (f[5:3] != 3'd7)       r = {1'b0, f[5:3]};
      else if (!f[2])           r = 4'd7;
      else if (f[1])            r = 4'd10;
      else                      r = f[0] ? 4'd9 : 4'd8;
    end
    return r;
  endfunction

endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
  parameter int WADDR_W = 18,
  parameter logic [15:0] KEY1_WORD = 16'h5555,
  parameter logic [15:0] KEY2_WORD = 16'h2AAA,
  parameter logic [15:0] KEY1_BYTE = 16'hAAAA,
  parameter logic [15:0] KEY2_BYTE = 16'h5555
) (
  input  logic [WADDR_W:0] addr,
  input  logic             byte_mode,
  output logic             at_key1,
  output logic             at_key2,
  output logic [5:0]       blk_field
);
  // The three most significant address bits take no part in the match.
  localparam int MW = WADDR_W - 3;

  logic w1, w2, b1, b2;

  always_comb begin
    w1 = addr[MW-1:0] == KEY1_WORD[MW-1:0];
    w2 = addr[MW-1:0] == KEY2_WORD[MW-1:0];
    b1 = addr[MW:0]   == KEY1_BYTE[MW:0];
    b2 = addr[MW:0]   == KEY2_BYTE[MW:0];
    at_key1   = byte_mode ? b1 : w1;
    at_key2   = byte_mode ? b2 : w2;
    blk_field = byte_mode ? addr[WADDR_W -: 6] : addr[WADDR_W-1 -: 6];
  end
endmodule

// File: rtl/fcd_block_map.sv
module fcd_block_map
  import fcd_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [5:0]         blk_field,
  output logic [NUM_BLK-1:0] blk_sel
);
  logic [3:0] idx;
  assign idx = blk_of_field(blk_field, TOP_BOOT);

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_sel
    assign blk_sel[i] = (idx == 4'(i));
  end
endmodule

// File: rtl/fcd_erase_window.sv
module fcd_erase_window
  import fcd_pkg::*;
#(
  parameter int WIN_CYC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_open,
  input  logic               first_blk,
  input  logic               add_blk,
  input  logic               all_blk,
  input  logic               drop,
  input  logic [NUM_BLK-1:0] blk_sel,
  output logic               expired,
  output logic [NUM_BLK-1:0] mask
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(WIN_CYC - 1);

  logic [CW-1:0]      cnt_q, cnt_n;
  logic [NUM_BLK-1:0] mask_q, mask_n;
  logic               cnt_en, mask_en;

  always_comb begin
    cnt_en  = 1'b0;
    cnt_n   = cnt_q;
    if (first_blk || add_blk) begin
      cnt_en = 1'b1;
      cnt_n  = CNT_LOAD;
    end else if (win_open && cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q - 1'b1;
    end

    mask_en = 1'b1;
    if (drop)            mask_n = '0;
    else if (all_blk)    mask_n = '1;
    else if (first_blk)  mask_n = blk_sel;
    else if (add_blk)    mask_n = mask_q | blk_sel;
    else begin
      mask_en = 1'b0;
      mask_n  = mask_q;
    end

    expired = win_open && !add_blk && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_n;
      if (mask_en) mask_q <= mask_n;
    end
  end

  assign mask = mask_q;

  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD);
  a_r6_expire_has_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> (mask_q != '0));
  a_r7_add_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    add_blk |=> (cnt_q == CNT_LOAD));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int WADDR_W  = 18,
  parameter int DATA_W   = 16,
  parameter int WIN_CYC  = 16,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [WADDR_W:0]   wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_byte,
  input  logic               done,
  output logic               prog_start,
  output logic [WADDR_W:0]   prog_addr,
  output logic [DATA_W-1:0]  prog_data,
  output logic               prog_byte,
  output logic               erase_start,
  output logic               erase_chip,
  output logic [NUM_BLK-1:0] erase_mask,
  output logic               suspend_pulse,
  output logic               resume_pulse,
  output logic               busy,
  output logic               suspended,
  output logic               autoselect
);
  fcd_state_e st_q, st_n;
  logic [7:0] op;
  logic at_key1, at_key2;
  logic [5:0] blk_field;
  logic [NUM_BLK-1:0] blk_sel;
  logic win_first, win_add, win_all, win_drop, win_expired;
  logic prg_go_n, ers_go_n, ers_chip_n, susp_n, resm_n, ident_n;
  logic prg_go_q, ers_go_q, ers_chip_q, susp_q, resm_q, ident_q;
  logic [WADDR_W:0]  paddr_q;
  logic [DATA_W-1:0] pdata_q;
  logic              pbyte_q;

  assign op = wr_data[7:0];

  fcd_addr_match #(.WADDR_W(WADDR_W)) u_match (
    .addr(wr_addr), .byte_mode(wr_byte),
    .at_key1(at_key1), .at_key2(at_key2), .blk_field(blk_field)
  );

  fcd_block_map #(.TOP_BOOT(TOP_BOOT)) u_map (
    .blk_field(blk_field), .blk_sel(blk_sel)
  );

  fcd_erase_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .win_open(st_q == ST_ERS_WIN),
    .first_blk(win_first), .add_blk(win_add), .all_blk(win_all),
    .drop(win_drop), .blk_sel(blk_sel), .expired(win_expired), .mask(erase_mask)
  );

  always_comb begin
    st_n       = st_q;
    prg_go_n   = 1'b0;
    ers_go_n   = 1'b0;
    ers_chip_n = 1'b0;
    susp_n     = 1'b0;
    resm_n     = 1'b0;
    ident_n    = ident_q && !wr_valid;
    win_first  = 1'b0;
    win_add    = 1'b0;
    win_all    = 1'b0;
    win_drop   = 1'b0;
    unique case (st_q)
      ST_READ:
        if (wr_valid) st_n = (op == OP_KEY_A && at_key1) ? ST_KEY1 : ST_READ;
      ST_KEY1:
        if (wr_valid) st_n = (op == OP_KEY_B && at_key2) ? ST_KEY2 : ST_READ;
      ST_KEY2:
        if (wr_valid) begin
          st_n = ST_READ;
          if (at_key1) begin
            if (op == OP_PROGRAM)      st_n = ST_PRG_ARG;
            else if (op == OP_ERS_ARM) st_n = ST_ERS_ARM;
            else if (op == OP_IDENT)   ident_n = 1'b1;
          end
        end
      ST_PRG_ARG:
        if (wr_valid) begin
          st_n     = ST_BUSY_PRG;
          prg_go_n = 1'b1;
        end
      ST_ERS_ARM:
        if (wr_valid) st_n = (op == OP_KEY_A && at_key1) ? ST_ERS_KEY1 : ST_READ;
      ST_ERS_KEY1:
        if (wr_valid) st_n = (op == OP_KEY_B && at_key2) ? ST_ERS_KEY2 : ST_READ;
      ST_ERS_KEY2:
        if (wr_valid) begin
          if (op == OP_ERS_CHIP && at_key1) begin
            st_n       = ST_BUSY_ERS;
            win_all    = 1'b1;
            ers_go_n   = 1'b1;
            ers_chip_n = 1'b1;
          end else if (op == OP_ERS_BLK) begin
            st_n      = ST_ERS_WIN;
            win_first = 1'b1;
          end else begin
            st_n = ST_READ;
          end
        end
      ST_ERS_WIN:
        if (wr_valid) begin
          if (op == OP_ERS_BLK) win_add = 1'b1;
          else begin
            st_n     = ST_READ;
            win_drop = 1'b1;
          end
        end else if (win_expired) begin
          st_n     = ST_BUSY_ERS;
          ers_go_n = 1'b1;
        end
      ST_BUSY_PRG:
        if (done) st_n = ST_READ;
      ST_BUSY_ERS:
        if (done) begin
          st_n     = ST_READ;
          win_drop = 1'b1;
        end else if (wr_valid && op == OP_SUSPEND) begin
          st_n   = ST_SUSP;
          susp_n = 1'b1;
        end
      ST_SUSP:
        if (wr_valid && op == OP_ERS_BLK) begin
          st_n   = ST_BUSY_ERS;
          resm_n = 1'b1;
        end
      default: st_n = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_READ;
      prg_go_q   <= 1'b0;
      ers_go_q   <= 1'b0;
      ers_chip_q <= 1'b0;
      susp_q     <= 1'b0;
      resm_q     <= 1'b0;
      ident_q    <= 1'b0;
      paddr_q    <= '0;
      pdata_q    <= '0;
      pbyte_q    <= 1'b0;
    end else begin
      st_q       <= st_n;
      prg_go_q   <= prg_go_n;
      ers_go_q   <= ers_go_n;
      ers_chip_q <= ers_chip_n;
      susp_q     <= susp_n;
      resm_q     <= resm_n;
      ident_q    <= ident_n;
      if (prg_go_n) begin
        paddr_q <= wr_addr;
        pdata_q <= wr_data;
        pbyte_q <= wr_byte;
      end
    end
  end

  assign prog_start    = prg_go_q;
  assign prog_addr     = paddr_q;
  assign prog_data     = pdata_q;
  assign prog_byte     = pbyte_q;
  assign erase_start   = ers_go_q;
  assign erase_chip    = ers_chip_q;
  assign suspend_pulse = susp_q;
  assign resume_pulse  = resm_q;
  assign busy          = (st_q == ST_BUSY_PRG) || (st_q == ST_BUSY_ERS);
  assign suspended     = (st_q == ST_SUSP);
  assign autoselect    = ident_q;

  a_r4_prog_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> busy);
  a_r10_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_start && erase_start));
  a_r10_prog_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY_PRG) |=> (!erase_start && !suspend_pulse && !resume_pulse));
  a_r5_chip_all_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start && erase_chip) |-> (&erase_mask));
  a_r11_suspend_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> suspend_pulse);
  a_r11_resume_exit: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> (busy && !suspended));
  a_r13_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY_ERS && done) |=> (!busy && erase_mask == '0));
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_byte, done;
  logic [18:0] wr_addr;
  logic [15:0] wr_data;
  logic        prog_start, prog_byte, erase_start, erase_chip;
  logic [18:0] prog_addr;
  logic [15:0] prog_data;
  logic [10:0] erase_mask;
  logic        suspend_pulse, resume_pulse, busy, suspended, autoselect;

  int vec = 0;
  int fails = 0;
  int cyc = 0;

  flash_cmd_decoder #(.WIN_CYC(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_byte(wr_byte), .done(done),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .prog_byte(prog_byte), .erase_start(erase_start), .erase_chip(erase_chip),
    .erase_mask(erase_mask), .suspend_pulse(suspend_pulse),
    .resume_pulse(resume_pulse), .busy(busy), .suspended(suspended),
    .autoselect(autoselect)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog act=%0d exp=<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint ex);
    vec++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, ex);
    end
  endtask

  function automatic logic [18:0] key_addr(input bit second, input bit bm, input logic [2:0] top);
    if (bm) return {top, second ? 16'h5555 : 16'hAAAA};
    else    return {1'b0, top, second ? 15'h2AAA : 15'h5555};
  endfunction

  // Block number from a word address, built from the address ranges.
  function automatic int exp_blk(input logic [17:0] wa);
    if (wa < 18'h02000) return 0;
    if (wa < 18'h03000) return 1;
    if (wa < 18'h04000) return 2;
    if (wa < 18'h08000) return 3;
    return 3 + int'(wa / 18'h08000);
  endfunction

  function automatic logic [17:0] word_of(input logic [18:0] a, input bit bm);
    return bm ? a[18:1] : a[17:0];
  endfunction

  task automatic wr(input logic [18:0] a, input logic [15:0] d, input bit bm);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_byte = bm;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock(input bit bm);
    wr(key_addr(0, bm, 3'($urandom)), 16'h00AA, bm);
    wr(key_addr(1, bm, 3'($urandom)), 16'h0055, bm);
  endtask

  task automatic finish_op();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic wait_erase(output int k);
    k = 0;
    while (!erase_start && k < WIN + 6) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic erase_prefix(input bit bm);
    unlock(bm);
    wr(key_addr(0, bm, 3'd0), 16'h0080, bm);
    unlock(bm);
  endtask

  initial begin
    logic [18:0] a;
    logic [15:0] d;
    logic [10:0] em;
    int k;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; wr_byte = 1'b0; done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !suspended && !autoselect, "R1 modes", {busy, suspended, autoselect}, 0);
    chk(erase_mask == 0 && !prog_start && !erase_start, "R1 mask/pulses", erase_mask, 0);

    // R2 + R4: word-mode program with high address bits set
    wr(19'h3D555, 16'h00AA, 0);
    wr(19'h3AAAA, 16'h0055, 0);
    wr(19'h05555, 16'h00A0, 0);
    wr(19'h12345, 16'hBEEF, 0);
    chk(prog_start, "R2 R4 prog_start", prog_start, 1);
    chk(prog_addr == 19'h12345 && prog_data == 16'hBEEF && !prog_byte, "R4 fields", prog_data, 16'hBEEF);
    chk(busy, "R4 busy", busy, 1);
    // R10: program busy ignores suspend and a full erase sequence
    wr(19'h0, 16'h00B0, 0);
    chk(!suspended && busy && !suspend_pulse, "R10 suspend ignored in program", suspended, 0);
    erase_prefix(0);
    wr(key_addr(0, 0, 3'd0), 16'h0010, 0);
    chk(!erase_start && erase_mask == 0, "R10 erase ignored in program", erase_mask, 0);
    finish_op();
    chk(!busy, "R13 done ends program", busy, 0);

    // R3: byte-mode program
    unlock(1);
    wr(key_addr(0, 1, 3'd5), 16'h00A0, 1);
    wr(19'h7FFFF, 16'h005A, 1);
    chk(prog_start && prog_byte && prog_addr == 19'h7FFFF, "R3 byte program", prog_addr, 19'h7FFFF);
    finish_op();

    // R5: chip erase
    erase_prefix(0);
    wr(key_addr(0, 0, 3'd7), 16'h0010, 0);
    chk(erase_start && erase_chip && erase_mask == 11'h7FF, "R5 chip erase", erase_mask, 11'h7FF);
    chk(busy, "R5 busy", busy, 1);
    // R10 erase busy ignores other writes
    wr(19'h0, 16'h00F0, 0);
    chk(busy && !suspended, "R10 reset ignored in erase", busy, 1);
    // R11 suspend/resume
    wr(19'h4321, 16'h00B0, 0);
    chk(suspend_pulse && suspended && !busy, "R11 suspend", {suspend_pulse, suspended, busy}, 3'b110);
    wr(19'h0, 16'h00F0, 0);
    finish_op();
    chk(suspended && erase_mask == 11'h7FF, "R11 writes and done ignored while suspended", erase_mask, 11'h7FF);
    wr(19'h1111, 16'h0030, 0);
    chk(resume_pulse && busy && !suspended, "R11 resume", {resume_pulse, busy}, 2'b11);
    finish_op();
    chk(!busy && erase_mask == 0, "R13 done clears erase", erase_mask, 0);

    // R6: single block erase with exact window timing (block 5)
    erase_prefix(0);
    wr(19'h16000, 16'h0030, 0);
    chk(erase_mask == 11'h020 && !erase_start, "R6 window open", erase_mask, 11'h020);
    wait_erase(k);
    chk(k == WIN, "R6 window length", k, WIN);
    chk(erase_start && !erase_chip && erase_mask == 11'h020, "R6 erase launch", erase_mask, 11'h020);
    finish_op();

    // R7: addition restarts window after partial run-down
    erase_prefix(1);
    wr(19'h00010, 16'h0030, 1);
    repeat (WIN - 4) @(negedge clk);
    wr(19'h05000, 16'h0030, 1);   // word 2800h: block 1
    wait_erase(k);
    chk(k == WIN, "R7 restart", k, WIN);
    chk(erase_mask == 11'h003, "R7 mask accumulates", erase_mask, 11'h003);
    finish_op();

    // R7: foreign write in window drops erase
    erase_prefix(0);
    wr(19'h30000, 16'h0030, 0);
    wr(19'h0, 16'h0077, 0);
    wait_erase(k);
    chk(!erase_start && erase_mask == 0 && !busy, "R7 drop", erase_mask, 0);

    // R9 + R12 autoselect
    unlock(0);
    wr(key_addr(0, 0, 3'd2), 16'h0090, 0);
    chk(autoselect, "R9 autoselect set", autoselect, 1);
    wr(19'h0, 16'h00F0, 0);
    chk(!autoselect && !busy, "R9 R12 cleared by reset write", autoselect, 0);

    // R12 deviations leave nothing behind
    unlock(0);
    wr(key_addr(0, 0, 3'd0), 16'h0077, 0);
    wr(19'h00100, 16'h00A0, 0);
    wr(19'h00200, 16'h1234, 0);
    chk(!prog_start && !busy, "R12 bad command", prog_start, 0);
    wr(key_addr(0, 0, 3'd0), 16'h00AA, 0);
    wr(19'h02AAB, 16'h0055, 0);
    wr(key_addr(0, 0, 3'd0), 16'h00A0, 0);
    wr(19'h00300, 16'h1234, 0);
    chk(!prog_start && !busy, "R12 bad second address", prog_start, 0);
    erase_prefix(0);
    wr(19'h00123, 16'h0010, 0);
    chk(!erase_start && erase_mask == 0 && !busy, "R12 chip confirm off key address", erase_mask, 0);

    // R8: one address in every block
    for (int b = 0; b < 11; b++) begin
      logic [17:0] wa;
      wa = (b == 0) ? 18'h01000 : (b == 1) ? 18'h02800 : (b == 2) ? 18'h03FFF :
           (b == 3) ? 18'h04000 : 18'((b - 3) * 32'h8000 + 32'h1234);
      erase_prefix(0);
      wr({1'b0, wa}, 16'h0030, 0);
      wait_erase(k);
      chk(erase_mask == 11'(1 << b) && exp_blk(wa) == b, "R8 block map", erase_mask, 11'(1 << b));
      finish_op();
    end

    // Random mix
    for (int it = 0; it < 60; it++) begin
      bit bm;
      int n;
      bm = 1'($urandom);
      if ($urandom % 2 == 0) begin
        a = 19'($urandom); d = 16'($urandom);
        if (!bm) a[18] = 1'b0;
        unlock(bm);
        wr(key_addr(0, bm, 3'($urandom)), 16'h00A0, bm);
        wr(a, d, bm);
        chk(prog_start && prog_addr == a && prog_data == d && prog_byte == bm, "R4 random program", prog_data, d);
        finish_op();
      end else begin
        n = 1 + int'($urandom % 3);
        em = '0;
        erase_prefix(bm);
        for (int j = 0; j < n; j++) begin
          a = 19'($urandom);
          if (!bm) a[18] = 1'b0;
          em[exp_blk(word_of(a, bm))] = 1'b1;
          wr(a, 16'h0030, bm);
        end
        wait_erase(k);
        chk(k == WIN && erase_start, "R6 random window", k, WIN);
        chk(erase_mask == em, "R7 R8 random mask", erase_mask, em);
        finish_op();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end
endmodule